// File: doc/BRIEF.md
# Mixed-Page-Size Fully-Associative Translation Buffer

This block caches virtual-to-physical translations for pages of three sizes (4 KB, 2 MB and 1 GB) in a single fully-associative array. No index field is taken from the address. The address splits only into a tag and an offset. Every slot keeps a tag as wide as the smallest page's tag, plus a per-slot mask. When a larger page is cached, the mask hides the tag bits that really belong to that page's offset. Those positions of the stored tag are written as zeros.

A lookup presents a virtual address. In the same cycle the block compares its masked tag against every valid slot and returns a hit flag, the slot number and the translated physical address. A fill presents a virtual address, a physical address and a size code. The block derives the mask and the padded tag itself and writes them into the slot chosen by a round-robin pointer. An invalidate-all input empties the whole array.

Top module: `tlbm_top`

## Requirements
- R1: After reset no lookup hits; `lk_hit` is 0, `lk_idx` is 0 and `lk_pa` is 0.
- R2: A page filled with `fl_size` 0 (4 KB) hits only when virtual bits 47:12 equal the filled ones. `lk_pa` is then physical bits 39:12 of the fill joined to virtual bits 11:0 of the lookup. Size code 3 behaves exactly like code 0.
- R3: A page filled with `fl_size` 1 (2 MB) hits whatever virtual bits 20:12 hold. `lk_pa` bits 20:0 come from the lookup address and bits 39:21 from the fill.
- R4: A page filled with `fl_size` 2 (1 GB) hits whatever virtual bits 29:12 hold. `lk_pa` bits 29:0 come from the lookup address and bits 39:30 from the fill.
- R5: A lookup that differs from a cached page in any virtual bit above that page's offset width misses.
- R6: At fill, the virtual and physical bits below the page's offset width are discarded. A fill address with nonzero low bits matches and translates the same as the aligned one.
- R7: Successive fills go to slots 0, 1, 2, … in turn and wrap from 15 to 0. The wrap overwrites the slot's previous translation.
- R8: On a hit, `lk_idx` is the number of the slot that matched, and the result appears in the same cycle as `lk_va`.
- R9: When several valid slots match, the lowest-numbered slot supplies `lk_idx` and `lk_pa`.
- R10: `flush_all` invalidates every slot and returns the fill pointer to slot 0 at the next edge. A fill requested in the same cycle is dropped.
- R11: On a miss, `lk_idx` and `lk_pa` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | A valid slot matched |
| lk_idx | output | 4 | Matching slot number |
| lk_pa | output | 40 | Translated physical address |
| fl_en | input | 1 | Write a translation this cycle |
| fl_va | input | 48 | Virtual address of the page to fill |
| fl_pa | input | 40 | Physical address of the page to fill |
| fl_size | input | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB, 3 = 4 KB |
| flush_all | input | 1 | Invalidate every slot |

## Verification
Each page size is probed with lookups that vary only the bits inside its offset, which must still hit. They are paired with lookups that flip the lowest bit just above the offset, which must miss. Together these pairs tell a correct mask from one that is shifted by a size step. Fills with junk in the low bits separate zero-padding from plain storage. A small page placed inside a cached 1 GB region forces a double hit and exposes the priority order. A run of sixteen-plus fills shows the pointer order and the overwrite at wrap. A flush issued together with a fill shows that the flush takes precedence.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   typedef enum logic [1:0] {
      PG_4K  = 2'd0,
      PG_2M  = 2'd1,
      PG_1G  = 2'd2,
      PG_RSV = 2'd3
   } pg_size_e;
endpackage

// File: rtl/tlbm_fill_fmt.sv
module tlbm_fill_fmt
   import tlbm_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int OFS_MIN = 12,
   parameter int OFS_MID = 21,
   parameter int OFS_MAX = 30,
   localparam int TAG_W  = VA_W - OFS_MIN,
   localparam int FR_W   = PA_W - OFS_MIN,
   localparam int MSK_W  = OFS_MAX - OFS_MIN
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PA_W-1:0]  pa,
   input  logic [1:0]       size,
   output logic [TAG_W-1:0] tag,
   output logic [FR_W-1:0]  frame,
   output logic [MSK_W-1:0] mask
);
   localparam int MID_SH = OFS_MID - OFS_MIN;

   logic [TAG_W-1:0] mask_t;
   logic [FR_W-1:0]  mask_f;

   always_comb begin
      case (pg_size_e'(size))
         PG_2M:   mask = {MSK_W{1'b1}} << MID_SH;
         PG_1G:   mask = '0;
         default: mask = {MSK_W{1'b1}};
      endcase
      mask_t = {{(TAG_W-MSK_W){1'b1}}, mask};
      mask_f = {{(FR_W-MSK_W){1'b1}}, mask};
      tag    = va[VA_W-1:OFS_MIN] & mask_t;
      frame  = pa[PA_W-1:OFS_MIN] & mask_f;
   end
endmodule

// File: rtl/tlbm_slot.sv
module tlbm_slot #(
   parameter int TAG_W = 36,
   parameter int FR_W  = 28,
   parameter int MSK_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [TAG_W-1:0] w_tag,
   input  logic [FR_W-1:0]  w_frame,
   input  logic [MSK_W-1:0] w_mask,
   input  logic [TAG_W-1:0] q_tag,
   output logic             valid,
   output logic             match,
   output logic [FR_W-1:0]  r_frame,
   output logic [MSK_W-1:0] r_mask
);
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    valid <= 1'b0;
      else if (clr)  valid <= 1'b0;
      else if (we)   valid <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_q   <= w_tag;
         r_frame <= w_frame;
         r_mask  <= w_mask;
      end
   end

   assign match = valid && ((q_tag & {{(TAG_W-MSK_W){1'b1}}, r_mask}) == tag_q);
endmodule

// File: rtl/tlbm_rr.sv
module tlbm_rr #(
   parameter int N       = 16,
   localparam int IDX_W  = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr,
   output logic [N-1:0]     sel
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr)   ptr <= '0;
      else if (adv)        ptr <= (ptr == IDX_W'(N-1)) ? '0 : ptr + 1'b1;
   end

   always_comb begin
      sel = '0;
      sel[ptr] = 1'b1;
   end
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top #(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int OFS_MIN = 12,
   parameter int OFS_MID = 21,
   parameter int OFS_MAX = 30,
   parameter int N       = 16,
   localparam int IDX_W  = $clog2(N),
   localparam int TAG_W  = VA_W - OFS_MIN,
   localparam int FR_W   = PA_W - OFS_MIN,
   localparam int MSK_W  = OFS_MAX - OFS_MIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VA_W-1:0]  lk_va,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PA_W-1:0]  lk_pa,
   input  logic             fl_en,
   input  logic [VA_W-1:0]  fl_va,
   input  logic [PA_W-1:0]  fl_pa,
   input  logic [1:0]       fl_size,
   input  logic             flush_all
);
   if (!(OFS_MIN < OFS_MID && OFS_MID < OFS_MAX && OFS_MAX < PA_W && PA_W <= VA_W))
      begin : g_bad_widths
         $error("tlbm_top: page offset widths must rise and fit below PA_W <= VA_W");
      end
   if (N < 2 || (1 << IDX_W) != N) begin : g_bad_depth
      $error("tlbm_top: N must be a power of two of at least 2");
   end

   logic [TAG_W-1:0] f_tag;
   logic [FR_W-1:0]  f_frame;
   logic [MSK_W-1:0] f_mask;
   logic             do_fill;
   logic [IDX_W-1:0] wr_ptr;
   logic [N-1:0]     wr_sel;
   logic [N-1:0]     valid_vec;
   logic [N-1:0]     hit_vec;
   logic [FR_W-1:0]  frame_a [N];
   logic [MSK_W-1:0] mask_a  [N];

   assign do_fill = fl_en && !flush_all;

   tlbm_fill_fmt #(
      .VA_W(VA_W), .PA_W(PA_W),
      .OFS_MIN(OFS_MIN), .OFS_MID(OFS_MID), .OFS_MAX(OFS_MAX)
   ) u_fmt (
      .va(fl_va), .pa(fl_pa), .size(fl_size),
      .tag(f_tag), .frame(f_frame), .mask(f_mask)
   );

   tlbm_rr #(.N(N)) u_rr (
      .clk(clk), .rst_n(rst_n), .clr(flush_all), .adv(do_fill),
      .ptr(wr_ptr), .sel(wr_sel)
   );

   for (genvar i = 0; i < N; i++) begin : g_slot
      tlbm_slot #(.TAG_W(TAG_W), .FR_W(FR_W), .MSK_W(MSK_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .clr(flush_all),
         .we(do_fill && wr_sel[i]),
         .w_tag(f_tag), .w_frame(f_frame), .w_mask(f_mask),
         .q_tag(lk_va[VA_W-1:OFS_MIN]),
         .valid(valid_vec[i]), .match(hit_vec[i]),
         .r_frame(frame_a[i]), .r_mask(mask_a[i])
      );
   end

   logic [FR_W-1:0] sel_frame;
   logic [FR_W-1:0] sel_mf;
   logic [FR_W-1:0] va_mid;

   always_comb begin
      lk_idx    = '0;
      sel_frame = '0;
      sel_mf    = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            lk_idx    = IDX_W'(i);
            sel_frame = frame_a[i];
            sel_mf    = {{(FR_W-MSK_W){1'b1}}, mask_a[i]};
         end
      end
      lk_hit = |hit_vec;
      va_mid = lk_va[PA_W-1:OFS_MIN];
      lk_pa  = lk_hit ? {(sel_frame & sel_mf) | (va_mid & ~sel_mf), lk_va[OFS_MIN-1:0]}
                      : '0;
   end
endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int OFS_MIN = 12,
   parameter int N       = 16,
   localparam int IDX_W  = $clog2(N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fl_en,
   input logic             flush_all,
   input logic [VA_W-1:0]  lk_va,
   input logic             lk_hit,
   input logic [IDX_W-1:0] lk_idx,
   input logic [PA_W-1:0]  lk_pa,
   input logic [N-1:0]     valid_vec,
   input logic [IDX_W-1:0] wr_ptr
);
   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_pa[OFS_MIN-1:0] == lk_va[OFS_MIN-1:0]);

   p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pa == '0 && lk_idx == '0));

   p_hit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> valid_vec[lk_idx]);

   p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (valid_vec == '0 && wr_ptr == '0));

   p_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !flush_all) |=>
         wr_ptr == (($past(wr_ptr) == IDX_W'(N-1)) ? '0 : $past(wr_ptr) + 1'b1));

   p_fill_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !flush_all) |=> valid_vec[$past(wr_ptr)]);
endmodule

bind tlbm_top tlbm_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .OFS_MIN(OFS_MIN), .N(N)
) u_chk (.*);

// File: tb/sim_tlbm_top.sv
`timescale 1ns/1ps
module sim_tlbm_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [47:0] lk_va;
   logic        lk_hit;
   logic [3:0]  lk_idx;
   logic [39:0] lk_pa;
   logic        fl_en;
   logic [47:0] fl_va;
   logic [39:0] fl_pa;
   logic [1:0]  fl_size;
   logic        flush_all;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tlbm_top u0 (
      .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_pa(lk_pa), .fl_en(fl_en), .fl_va(fl_va), .fl_pa(fl_pa),
      .fl_size(fl_size), .flush_all(flush_all)
   );

   function automatic logic [39:0] xpa(logic [39:0] p, logic [47:0] v, int ofs);
      logic [39:0] m = (40'd1 << ofs) - 40'd1;
      return (p & ~m) | (v[39:0] & m);
   endfunction

   task automatic look(string req, logic [47:0] va, logic eh, logic [3:0] ei,
                       logic [39:0] ep);
      @(negedge clk);
      lk_va = va;
      #1;
      checks++;
      if (lk_hit !== eh || lk_idx !== ei || lk_pa !== ep) begin
         errors++;
         $display("FAIL %s va=%h: got hit=%b idx=%0d pa=%h, expected hit=%b idx=%0d pa=%h",
                  req, va, lk_hit, lk_idx, lk_pa, eh, ei, ep);
      end
   endtask

   task automatic fill(logic [47:0] va, logic [39:0] pa, logic [1:0] sz);
      @(negedge clk);
      fl_en = 1'b1; fl_va = va; fl_pa = pa; fl_size = sz;
      @(negedge clk);
      fl_en = 1'b0;
   endtask

   localparam logic [47:0] VA_A = 48'h1234_5678_9000;
   localparam logic [39:0] PA_A = 40'hAB_CDE0_1000;
   localparam logic [47:0] VA_B = 48'h0000_7FC0_0000 | 48'h1A_B000;
   localparam logic [39:0] PA_B = 40'h12_3460_0000 | 40'h5_F000;
   localparam logic [47:0] VA_C = 48'h00AB_C000_0000 | 48'h1234_5000;
   localparam logic [39:0] PA_C = 40'h80_4000_0000 | 40'h0777_7000;
   localparam logic [47:0] VA_S3 = 48'h3333_0000_0000;
   localparam logic [39:0] PA_S3 = 40'h33_0000_0000;

   task automatic t_reset;
      rst_n = 1'b0; fl_en = 1'b0; flush_all = 1'b0;
      fl_va = '0; fl_pa = '0; fl_size = '0; lk_va = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look("R1", VA_A, 1'b0, 4'd0, 40'd0);
      look("R1", 48'd0, 1'b0, 4'd0, 40'd0);
   endtask

   task automatic t_small;
      fill(VA_A, PA_A, 2'd0);
      look("R2", VA_A | 48'h345, 1'b1, 4'd0, xpa(PA_A, VA_A | 48'h345, 12));
      look("R5", VA_A ^ 48'h1000, 1'b0, 4'd0, 40'd0);
   endtask

   task automatic t_mid;
      logic [47:0] v;
      fill(VA_B, PA_B, 2'd1);
      v = 48'h0000_7FC0_0000 | 48'h0F_2345;
      look("R3", v, 1'b1, 4'd1, xpa(PA_B, v, 21));
      look("R6", VA_B, 1'b1, 4'd1, xpa(PA_B, VA_B, 21));
      look("R5", v ^ (48'd1 << 21), 1'b0, 4'd0, 40'd0);
   endtask

   task automatic t_large;
      logic [47:0] v;
      fill(VA_C, PA_C, 2'd2);
      v = 48'h00AB_C000_0000 | 48'h3FFF_FFFF;
      look("R4", v, 1'b1, 4'd2, xpa(PA_C, v, 30));
      look("R6", 48'h00AB_C000_0000, 1'b1, 4'd2, xpa(PA_C, 48'h00AB_C000_0000, 30));
      look("R5", v ^ (48'd1 << 30), 1'b0, 4'd0, 40'd0);
   endtask

   task automatic t_size3;
      fill(VA_S3, PA_S3, 2'd3);
      look("R2", VA_S3 | 48'hFFF, 1'b1, 4'd3, xpa(PA_S3, VA_S3 | 48'hFFF, 12));
      look("R2", VA_S3 ^ 48'h1000, 1'b0, 4'd0, 40'd0);
   endtask

   task automatic t_multi;
      logic [47:0] d = 48'h00AB_C123_4000;
      fill(d, 40'h01_0000_0000, 2'd0);
      look("R9", d | 48'h10, 1'b1, 4'd2, xpa(PA_C, d | 48'h10, 30));
   endtask

   task automatic t_rr;
      logic [47:0] v;
      for (int i = 5; i < 16; i++) begin
         v = 48'h5555_0000_0000 | (48'(i) << 12);
         fill(v, 40'h20_0000_0000 | (40'(i) << 12), 2'd0);
         look("R7", v, 1'b1, 4'(i), 40'h20_0000_0000 | (40'(i) << 12));
      end
      v = 48'h6666_0000_0000;
      fill(v, 40'h66_0000_0000, 2'd0);
      look("R7", v | 48'h9, 1'b1, 4'd0, 40'h66_0000_0009);
      look("R7", VA_A, 1'b0, 4'd0, 40'd0);
      look("R8", VA_B, 1'b1, 4'd1, xpa(PA_B, VA_B, 21));
   endtask

   task automatic t_flush;
      logic [47:0] e = 48'h7777_0000_0000;
      @(negedge clk);
      flush_all = 1'b1; fl_en = 1'b1; fl_va = e; fl_pa = 40'h77_0000_0000; fl_size = 2'd0;
      @(negedge clk);
      flush_all = 1'b0; fl_en = 1'b0;
      look("R10", 48'h00AB_C000_0000, 1'b0, 4'd0, 40'd0);
      look("R10", e, 1'b0, 4'd0, 40'd0);
      look("R10", VA_B, 1'b0, 4'd0, 40'd0);
      fill(48'h0888_0000_1000, 40'h08_8000_1000, 2'd0);
      look("R10", 48'h0888_0000_1000, 1'b1, 4'd0, 40'h08_8000_1000);
      look("R11", 48'h0888_0000_2000, 1'b0, 4'd0, 40'd0);
   endtask

   initial begin
      t_reset;
      t_small;
      t_mid;
      t_large;
      t_size3;
      t_multi;
      t_rr;
      t_flush;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule